// File: doc/BRIEF.md
# Block-Granular Memory Attribute Controller

This block keeps a small attribute word for every 64 KB block of a 16 MB physical address space and turns it, for each CPU access, into a routing decision. The decision is one of three outcomes: on-board RAM, the external bus, or a blocked write. Each attribute word carries one ownership flag per RAM source and one write-protect flag. A 4 KB register window gives software three things: a pair of read-only diagnostics bytes that describe the installed memory, a read/write setup pair whose low byte also carries the external-cache enable, and a write-only relocation control that sits behind the diagnostics offsets. Writing the relocation control hands the two shadow blocks just below 1 MB to system RAM, and it can write-protect those blocks together with the two top blocks below 16 MB.

Register accesses may be 1, 2 or 4 bytes wide. A wide access is split into byte lanes at consecutive offsets, least significant byte at the lowest offset, and every lane is handled in the same cycle. Access steering is purely combinational from the attribute array. A small notifier state machine compares the live attributes with the copy it last applied. For each block that differs it emits a one-cycle `attr_changed` pulse carrying the block index, so that translation caches further downstream can drop stale entries.

The notifier has two states. `NT_IDLE` waits for a difference and, on finding one, latches the lowest differing block index and moves to `NT_NOTIFY`. `NT_NOTIFY` drives the pulse, copies that block's live attribute into the applied copy, and always returns to `NT_IDLE`.

Top module: `blkattr_ctrl`

## Requirements
- R1: After reset, a 32-bit read at offset 0 returns 0xFC44FD8F. Byte 0 is 0x8F (bit 7 set, base-memory code 0x00 for 640 KB, low nibble 0xF meaning no parity error). Byte 1 is 0xFD, byte 2 (setup low) is 0x44 and byte 3 (setup high) is 0xFC. `cache_en` is 1.
- R2: Offsets 4 to 0xFFF read 0xFF. Writes to them change no register and no attribute.
- R3: Writes to offsets 0 and 1 never change the diagnostics bytes read back there.
- R4: Offsets 2 and 3 read back the last byte written to them. `cache_en` equals bit 6 of offset 2.
- R5: `reg_size` 0, 1 and 2-or-3 select 1, 2 and 4 byte lanes. Lane i uses offset (`reg_addr`+i) mod 4096 and data bits [8i+7:8i]. Lanes that are not selected read 0xFF and write nothing.
- R6: The attribute bits are: system owner 0x01, module A 0x04, module B 0x08, module C 0x10, write-protect 0x20. Any owner bit gives `rd_internal`=1. An owner bit without write-protect gives `wr_internal`=1. Write-protect gives `wr_blocked`=1. Zero means bus for both reads and writes.
- R7: A byte written to offset 0 first clears the system and write-protect bits of blocks 0x0E and 0x0F and the write-protect bit of blocks 0xFE and 0xFF. Then, if bit 0 of the byte is 0, blocks 0x0E and 0x0F get the system bit. If bit 1 is 0, all four blocks get the write-protect bit.
- R8: At reset, blocks 0x00 to 0x09 and 0xFA to 0xFF hold 0x01 and every other block holds 0x00. This state is the one that a relocation byte of 0xFF produces.
- R9: A write to offset 1 changes no block attribute.
- R10: Every block whose attribute differs from its applied copy gives exactly one `attr_changed` pulse, one cycle wide, with its index on `attr_idx`. Pulses come in ascending index order and are separated by at least one low cycle. No pulse follows reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | Access is a write |
| reg_addr | input | 12 | Window offset of the lowest byte |
| reg_size | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| reg_wdata | input | 32 | Write data, byte lane i in bits [8i+7:8i] |
| reg_rdata | output | 32 | Combinational read data, unselected lanes 0xFF |
| cache_en | output | 1 | External cache enable (bit 6 of offset 2) |
| acc_blk | input | 8 | Address bits [23:16] of the current CPU access |
| rd_internal | output | 1 | Reads of that block go to on-board RAM |
| wr_internal | output | 1 | Writes of that block go to on-board RAM |
| wr_blocked | output | 1 | Writes of that block are discarded |
| attr_changed | output | 1 | One-cycle pulse for a changed block |
| attr_idx | output | 8 | Index of the block announced by the pulse |

## Verification
Directed relocation bytes walk all four combinations of bits 0 and 1. Together they separate ownership, pure write-protect with bus reads, and the unlocked state, and each one checks the steering outputs as well as the ordered list of change pulses. Wide accesses that straddle the top of the window and that cover relocation and setup lanes at once show that lanes are ordered and split correctly. A seeded random mix of writes at arbitrary offsets and widths, reads, and steering probes is compared against a bench model. That model separates real register offsets from dead ones and writes that change attributes from writes that leave them as they are.

// File: rtl/blkattr_pkg.sv
package blkattr_pkg;

    localparam int ATTR_W = 6;

    localparam logic [ATTR_W-1:0] ATTR_SYS  = 6'h01;
    localparam logic [ATTR_W-1:0] ATTR_MODA = 6'h04;
    localparam logic [ATTR_W-1:0] ATTR_MODB = 6'h08;
    localparam logic [ATTR_W-1:0] ATTR_MODC = 6'h10;
    localparam logic [ATTR_W-1:0] ATTR_WP   = 6'h20;
    localparam logic [ATTR_W-1:0] ATTR_OWNERS = ATTR_SYS | ATTR_MODA | ATTR_MODB | ATTR_MODC;

    typedef enum logic [0:0] {
        NT_IDLE,
        NT_NOTIFY
    } notify_state_e;

    // Diagnostics byte 0: bit 7 always set, base-memory code, clean parity nibble.
    function automatic logic [7:0] diag_low_byte(int base_kb);
        logic [7:0] code;
        if (base_kb >= 640)      code = 8'h00;
        else if (base_kb >= 512) code = 8'h20;
        else if (base_kb >= 256) code = 8'h30;
        else                     code = 8'h10;
        return 8'h80 | code | 8'h0F;
    endfunction

    // Attribute of block b after reset: base RAM at the bottom, ROM shadow at the top.
    function automatic logic [ATTR_W-1:0] blk_reset_attr(int b, int base_kb, int high_first);
        if ((b < base_kb / 64) || (b >= high_first)) return ATTR_SYS;
        return '0;
    endfunction

endpackage

// File: rtl/blkattr_regs.sv
module blkattr_regs
    import blkattr_pkg::*;
#(
    parameter int         OFF_W        = 12,
    parameter int         LANES        = 4,
    parameter int         BASE_KB      = 640,
    parameter logic [7:0] DIAG_HI      = 8'hFD,
    parameter logic [7:0] SETUP_LO_RST = 8'h44,
    parameter logic [7:0] SETUP_HI_RST = 8'hFC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_en,
    input  logic               reg_we,
    input  logic [OFF_W-1:0]   reg_addr,
    input  logic [1:0]         reg_size,
    input  logic [8*LANES-1:0] reg_wdata,
    output logic [8*LANES-1:0] reg_rdata,
    output logic               reloc_wr,
    output logic [7:0]         reloc_val,
    output logic               cache_en
);

    localparam logic [7:0] DIAG_LO = diag_low_byte(BASE_KB);

    logic [7:0] setup_lo_q, setup_hi_q;
    logic       lo_wr, hi_wr;
    logic [7:0] lo_wd, hi_wd;
    logic       wr_any;

    assign wr_any = reg_en && reg_we;

    // Lane split: lane i targets offset reg_addr+i, byte i of the data bus.
    always_comb begin
        lo_wr = 1'b0;  hi_wr = 1'b0;  reloc_wr = 1'b0;
        lo_wd = '0;    hi_wd = '0;    reloc_val = '0;
        reg_rdata = '1;
        for (int i = 0; i < LANES; i++) begin
            logic [OFF_W-1:0] off;
            logic [7:0]       rb;
            off = reg_addr + OFF_W'(i);
            if (i < (32'd1 << reg_size)) begin
                unique case (off)
                    OFF_W'(0): rb = DIAG_LO;
                    OFF_W'(1): rb = DIAG_HI;
                    OFF_W'(2): rb = setup_lo_q;
                    OFF_W'(3): rb = setup_hi_q;
                    default:   rb = 8'hFF;
                endcase
                reg_rdata[8*i +: 8] = rb;
                if (off == OFF_W'(0)) begin
                    reloc_wr  = wr_any;
                    reloc_val = reg_wdata[8*i +: 8];
                end
                if (off == OFF_W'(2)) begin
                    lo_wr = wr_any;
                    lo_wd = reg_wdata[8*i +: 8];
                end
                if (off == OFF_W'(3)) begin
                    hi_wr = wr_any;
                    hi_wd = reg_wdata[8*i +: 8];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_lo_q <= SETUP_LO_RST;
            setup_hi_q <= SETUP_HI_RST;
        end else begin
            if (lo_wr) setup_lo_q <= lo_wd;
            if (hi_wr) setup_hi_q <= hi_wd;
        end
    end

    assign cache_en = setup_lo_q[6];

    AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ($stable(setup_lo_q) && $stable(setup_hi_q)))
        else $error("setup port changed without a write"); // R4

endmodule

// File: rtl/blkattr_array.sv
module blkattr_array
    import blkattr_pkg::*;
#(
    parameter int NBLK       = 256,
    parameter int BASE_KB    = 640,
    parameter int HIGH_FIRST = 250,
    parameter int LO_PAIR    = 14,
    parameter int IDX_W      = $clog2(NBLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reloc_wr,
    input  logic [7:0]             reloc_val,
    input  logic [IDX_W-1:0]       acc_blk,
    output logic                   rd_internal,
    output logic                   wr_internal,
    output logic                   wr_blocked,
    output logic [NBLK*ATTR_W-1:0] attr_flat
);

    localparam int HI_PAIR = NBLK - 2;

    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        localparam bit IS_LO = (b == LO_PAIR) || (b == LO_PAIR + 1);
        localparam bit IS_HI = (b == HI_PAIR) || (b == HI_PAIR + 1);
        localparam logic [ATTR_W-1:0] RST = blk_reset_attr(b, BASE_KB, HIGH_FIRST);
        logic [ATTR_W-1:0] cur;

        if (IS_LO || IS_HI) begin : g_reloc
            logic [ATTR_W-1:0] nxt;
            always_comb begin
                if (IS_LO) begin
                    nxt = cur & ~(ATTR_SYS | ATTR_WP);
                    if (!reloc_val[0]) nxt = nxt | ATTR_SYS;
                end else begin
                    nxt = cur & ~ATTR_WP;
                end
                if (!reloc_val[1]) nxt = nxt | ATTR_WP;
            end
            always_ff @(posedge clk) begin
                if (!rst_n)        cur <= RST;
                else if (reloc_wr) cur <= nxt;
            end

            AST_RELOC_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
                (reloc_wr && !reloc_val[1]) |=> ((cur & ATTR_WP) != '0))
                else $error("relocation lock not applied"); // R7
            if (IS_LO) begin : g_lo_chk
                AST_RELOC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
                    (reloc_wr && reloc_val[0]) |=> ((cur & ATTR_SYS) == '0))
                    else $error("shadow block kept system ownership"); // R7
            end
        end else begin : g_fixed
            assign cur = RST;
        end

        assign attr_flat[b*ATTR_W +: ATTR_W] = cur;
    end

    // Access steering for the block under the current CPU address.
    logic [ATTR_W-1:0] sel;
    assign sel         = attr_flat[int'(acc_blk)*ATTR_W +: ATTR_W];
    assign rd_internal = (sel & ATTR_OWNERS) != '0;
    assign wr_blocked  = (sel & ATTR_WP) != '0;
    assign wr_internal = rd_internal && !wr_blocked;

endmodule

// File: rtl/blkattr_notify.sv
module blkattr_notify
    import blkattr_pkg::*;
#(
    parameter int NBLK       = 256,
    parameter int BASE_KB    = 640,
    parameter int HIGH_FIRST = 250,
    parameter int IDX_W      = $clog2(NBLK)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NBLK*ATTR_W-1:0] attr_flat,
    output logic                   attr_changed,
    output logic [IDX_W-1:0]       attr_idx
);

    function automatic logic [NBLK*ATTR_W-1:0] reset_image();
        logic [NBLK*ATTR_W-1:0] v;
        for (int b = 0; b < NBLK; b++)
            v[b*ATTR_W +: ATTR_W] = blk_reset_attr(b, BASE_KB, HIGH_FIRST);
        return v;
    endfunction

    localparam logic [NBLK*ATTR_W-1:0] APPLIED_RST = reset_image();

    notify_state_e          state_q, state_d;
    logic [NBLK*ATTR_W-1:0] applied_q;
    logic [IDX_W-1:0]       hit_q, pick;
    logic                   found;

    // Lowest block whose live attribute differs from the applied copy.
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NBLK - 1; i >= 0; i--) begin
            if (attr_flat[i*ATTR_W +: ATTR_W] != applied_q[i*ATTR_W +: ATTR_W]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NT_IDLE:   if (found) state_d = NT_NOTIFY;
            NT_NOTIFY: state_d = NT_IDLE;
            default:   state_d = NT_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= NT_IDLE;
            hit_q     <= '0;
            applied_q <= APPLIED_RST;
        end else begin
            state_q <= state_d;
            if (state_q == NT_IDLE && found) hit_q <= pick;
            if (state_q == NT_NOTIFY)
                applied_q[int'(hit_q)*ATTR_W +: ATTR_W] <= attr_flat[int'(hit_q)*ATTR_W +: ATTR_W];
        end
    end

    always_comb begin
        attr_changed = (state_q == NT_NOTIFY);
        attr_idx     = hit_q;
    end

    AST_PULSE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        attr_changed |=> !attr_changed)
        else $error("change pulse wider than one cycle"); // R10
    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        attr_changed |-> $past(found))
        else $error("change pulse without a differing block"); // R10

endmodule

// File: rtl/blkattr_ctrl.sv
module blkattr_ctrl
    import blkattr_pkg::*;
#(
    parameter int         NBLK         = 256,
    parameter int         OFF_W        = 12,
    parameter int         LANES        = 4,
    parameter int         BASE_KB      = 640,
    parameter int         HIGH_FIRST   = 250,
    parameter int         LO_PAIR      = 14,
    parameter logic [7:0] DIAG_HI      = 8'hFD,
    parameter logic [7:0] SETUP_LO_RST = 8'h44,
    parameter logic [7:0] SETUP_HI_RST = 8'hFC,
    localparam int        IDX_W        = $clog2(NBLK),
    localparam int        DATA_W       = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [OFF_W-1:0]  reg_addr,
    input  logic [1:0]        reg_size,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              cache_en,
    input  logic [IDX_W-1:0]  acc_blk,
    output logic              rd_internal,
    output logic              wr_internal,
    output logic              wr_blocked,
    output logic              attr_changed,
    output logic [IDX_W-1:0]  attr_idx
);

    logic                   reloc_wr;
    logic [7:0]             reloc_val;
    logic [NBLK*ATTR_W-1:0] attr_flat;

    blkattr_regs #(
        .OFF_W(OFF_W), .LANES(LANES), .BASE_KB(BASE_KB), .DIAG_HI(DIAG_HI),
        .SETUP_LO_RST(SETUP_LO_RST), .SETUP_HI_RST(SETUP_HI_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .reloc_wr(reloc_wr), .reloc_val(reloc_val),
        .cache_en(cache_en)
    );

    blkattr_array #(
        .NBLK(NBLK), .BASE_KB(BASE_KB), .HIGH_FIRST(HIGH_FIRST), .LO_PAIR(LO_PAIR)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .reloc_wr(reloc_wr), .reloc_val(reloc_val),
        .acc_blk(acc_blk), .rd_internal(rd_internal), .wr_internal(wr_internal),
        .wr_blocked(wr_blocked), .attr_flat(attr_flat)
    );

    blkattr_notify #(
        .NBLK(NBLK), .BASE_KB(BASE_KB), .HIGH_FIRST(HIGH_FIRST)
    ) u_notify (
        .clk(clk), .rst_n(rst_n), .attr_flat(attr_flat),
        .attr_changed(attr_changed), .attr_idx(attr_idx)
    );

    AST_STEER_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_internal && wr_blocked))
        else $error("write both internal and blocked"); // R6

endmodule

// File: tb/test_blkattr_ctrl.sv
module test_blkattr_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_en, reg_we;
    logic [11:0] reg_addr;
    logic [1:0]  reg_size;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        cache_en;
    logic [7:0]  acc_blk;
    logic        rd_internal, wr_internal, wr_blocked;
    logic        attr_changed;
    logic [7:0]  attr_idx;

    always #10 clk = ~clk;

    blkattr_ctrl i_blkattr_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cache_en(cache_en), .acc_blk(acc_blk),
        .rd_internal(rd_internal), .wr_internal(wr_internal), .wr_blocked(wr_blocked),
        .attr_changed(attr_changed), .attr_idx(attr_idx)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [5:0] m_attr [256];
    logic [7:0] m_setup [2];

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic void model_reset();
        for (int b = 0; b < 256; b++) m_attr[b] = (b < 10 || b >= 250) ? 6'h01 : 6'h00;
        m_setup[0] = 8'h44;
        m_setup[1] = 8'hFC;
    endfunction

    function automatic void model_reloc(logic [7:0] v);
        for (int b = 14; b <= 15; b++) begin
            m_attr[b] = m_attr[b] & ~6'h21;
            if (!v[0]) m_attr[b] = m_attr[b] | 6'h01;
            if (!v[1]) m_attr[b] = m_attr[b] | 6'h20;
        end
        for (int b = 254; b <= 255; b++) begin
            m_attr[b] = m_attr[b] & ~6'h20;
            if (!v[1]) m_attr[b] = m_attr[b] | 6'h20;
        end
    endfunction

    function automatic logic [7:0] exp_byte(logic [11:0] off);
        case (off)
            12'd0:   return 8'h8F;
            12'd1:   return 8'hFD;
            12'd2:   return m_setup[0];
            12'd3:   return m_setup[1];
            default: return 8'hFF;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(logic [11:0] addr, logic [1:0] size);
        logic [31:0] r;
        for (int i = 0; i < 4; i++)
            r[8*i +: 8] = (i < (1 << size)) ? exp_byte(addr + 12'(i)) : 8'hFF;
        return r;
    endfunction

    function automatic logic [2:0] exp_steer(logic [5:0] a);
        logic rd, bl;
        rd = (a & 6'h1D) != 0;
        bl = a[5];
        return {rd, rd && !bl, bl};
    endfunction

    task automatic check_read(logic [11:0] addr, logic [1:0] size, string req);
        @(negedge clk);
        reg_addr = addr;
        reg_size = size;
        #1;
        chk(req, $sformatf("read @%h size %0d", addr, size), reg_rdata, exp_read(addr, size));
    endtask

    task automatic check_steer(logic [7:0] b, string req);
        @(negedge clk);
        acc_blk = b;
        #1;
        chk(req, $sformatf("steer block %h", b), {29'd0, rd_internal, wr_internal, wr_blocked},
            {29'd0, exp_steer(m_attr[b])});
    endtask

    task automatic watch(int n, logic [7:0] el [4], string req);
        logic prev = 1'b0;
        int   got  = 0;
        repeat (24) begin
            @(negedge clk);
            if (attr_changed) begin
                if (prev) chk(req, "pulse width", 1, 0);
                if (got < n) chk(req, "changed index", attr_idx, el[got]);
                got++;
            end
            prev = attr_changed;
        end
        chk(req, "pulse count", got, n);
    endtask

    task automatic bus_write(logic [11:0] addr, logic [1:0] size, logic [31:0] data, string req);
        logic [5:0] old [256];
        logic [7:0] el [4];
        int n = 0;
        old = m_attr;
        for (int i = 0; i < 4; i++) begin
            if (i < (1 << size)) begin
                logic [11:0] off;
                off = addr + 12'(i);
                if (off == 12'd0) model_reloc(data[8*i +: 8]);
                if (off == 12'd2) m_setup[0] = data[8*i +: 8];
                if (off == 12'd3) m_setup[1] = data[8*i +: 8];
            end
        end
        for (int i = 0; i < 4; i++) el[i] = 8'h00;
        for (int b = 0; b < 256; b++)
            if (m_attr[b] != old[b] && n < 4) begin
                el[n] = 8'(b);
                n++;
            end
        @(negedge clk);
        reg_en = 1'b1; reg_we = 1'b1;
        reg_addr = addr; reg_size = size; reg_wdata = data;
        @(posedge clk);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        watch(n, el, req);
        chk("R4", "cache_en", {31'd0, cache_en}, {31'd0, m_setup[0][6]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] e0 [4];
        int seed;
        for (int i = 0; i < 4; i++) e0[i] = 8'h00;
        seed = $urandom(32'h5EED_0A77);
        rst_n = 1'b0; reg_en = 1'b0; reg_we = 1'b0;
        reg_addr = '0; reg_size = '0; reg_wdata = '0; acc_blk = '0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset register values and cache enable
        check_read(12'h000, 2'd2, "R1");
        chk("R1", "cache_en at reset", {31'd0, cache_en}, 32'd1);
        // R10 no pulses after reset
        watch(0, e0, "R10");
        // R8 reset attributes, R6 steering
        check_steer(8'h00, "R8");
        check_steer(8'h09, "R8");
        check_steer(8'h0A, "R8");
        check_steer(8'h0E, "R8");
        check_steer(8'hFA, "R6");
        check_steer(8'hFF, "R6");
        // R2 dead offsets
        check_read(12'h004, 2'd0, "R2");
        check_read(12'h7FF, 2'd0, "R2");
        bus_write(12'h010, 2'd0, 32'h12, "R2");
        check_read(12'h000, 2'd2, "R2");
        // R5 window wrap and lane mask
        check_read(12'hFFF, 2'd1, "R5");
        check_read(12'h001, 2'd0, "R5");
        // R4 setup port
        bus_write(12'h002, 2'd0, 32'h05, "R4");
        check_read(12'h002, 2'd0, "R4");
        bus_write(12'h002, 2'd0, 32'h40, "R4");
        // R7 relocation byte cases, R3 diagnostics untouched
        bus_write(12'h000, 2'd0, 32'h00, "R7");
        check_steer(8'h0E, "R7");
        check_steer(8'hFE, "R7");
        check_read(12'h000, 2'd1, "R3");
        bus_write(12'h000, 2'd0, 32'h02, "R7");
        check_steer(8'h0F, "R7");
        bus_write(12'h000, 2'd0, 32'h01, "R7");
        check_steer(8'h0E, "R6");
        check_steer(8'hFF, "R6");
        // R9 offset 1 has no attribute effect
        bus_write(12'h001, 2'd0, 32'h00, "R9");
        check_steer(8'h0E, "R9");
        check_read(12'h000, 2'd1, "R3");
        bus_write(12'h000, 2'd0, 32'h03, "R7");
        // R5 wide writes
        bus_write(12'h002, 2'd1, 32'h0000A55A, "R5");
        check_read(12'h000, 2'd2, "R5");
        bus_write(12'h000, 2'd2, 32'h33447700, "R5");
        check_read(12'h000, 2'd3, "R5");
        check_steer(8'h0E, "R5");

        // Seeded random mix
        for (int it = 0; it < 250; it++) begin
            int op;
            logic [11:0] a;
            op = $urandom % 3;
            a  = ($urandom % 4 == 0) ? 12'($urandom % 4096) : 12'($urandom % 6);
            if (op == 0) bus_write(a, 2'($urandom % 4), $urandom, "R7");
            else if (op == 1) check_read(a, 2'($urandom % 4), "R5");
            else check_steer(($urandom % 2 == 0) ? 8'(8'h0E + $urandom % 2) : 8'($urandom % 256), "R6");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule